// File: doc/BRIEF.md
# Keyed Dual-Image Raster Compositor

This block sits behind a free-running 640x480 sync generator. It draws two copies of one small stored RGB picture side by side on the visible raster. The generator supplies the current column and row counts, a flag that marks visible pixels, and a pixel enable. The enable is high on every second cycle of the system clock, which gives a 25 MHz pixel rate from a 50 MHz clock. The block computes the image-memory address for the current position and holds a synthesizable pattern memory of 224x224 three-bit words. It drives one bit each of red, green and blue.

The left copy reproduces the stored colours exactly. The right copy passes each pixel through a scrambler that is keyed by three slide-switch bits. When the switch value equals a built-in secret, the right copy looks like the left one. Any other value flips colour bits. A reviewer of the picture can therefore tell at a glance whether the correct key was entered.

The memory read takes one registered stage. The window selection and the switch-derived mask are registered on the same enable edge, so every colour lines up with the position that was presented. There is no streaming traffic, so all pins are plain level signals with no valid/ready handshake.

Top module: `vga_dual_compositor`

## Requirements
- R1: While reset is high, and on the first clock after it, red, green and blue are all low.
- R2: A visible pixel inside the left window (columns 96..319, rows 128..351) shows the stored word unchanged, registered on the enable edge that sampled its position.
- R3: A visible pixel inside the right window (columns 416..639, rows 128..351) shows the stored word XOR (switches XOR 3'b010), bit 2 being red, bit 1 green and bit 0 blue.
- R4: With the switches at 3'b010 (switch 0 low, switch 1 high, switch 2 low), the same image position gives identical colours in both windows.
- R5: Outside both windows, or when the visible flag is low, the colour outputs become low at the next enable edge.
- R6: The address output is combinational: (row-128)*224 + (column - window start) inside a window, and 0 elsewhere. It never reaches 50176.
- R7: The stored word at address a is (a[7:5] + a[12:10]) mod 8, packed as {red, green, blue}.
- R8: On clock edges where the enable is low, the colour outputs hold their value, whatever the position and switch inputs do.
- R9: The window edges are exact. Columns 95 and 320 and rows 127 and 352 fall outside. Columns 96, 319, 416 and 639 fall inside on rows 128 and 351.
- R10: The switches are sampled only on enable edges. A switch change during a low enable alters nothing until the next enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz in the target use) |
| rst | input | 1 | Active-high synchronous reset |
| pix_en | input | 1 | Pixel enable, one cycle in two |
| hcount | input | 10 | Current column count |
| vcount | input | 10 | Current row count |
| active | input | 1 | High during the visible part of the raster |
| key_sw | input | 3 | Switch code entered by the user |
| rom_addr | output | 16 | Image memory address for the current position |
| red | output | 1 | Red colour bit |
| green | output | 1 | Green colour bit |
| blue | output | 1 | Blue colour bit |

## Verification
Two functions can act on the same enable edge: the switch code can change exactly while the raster crosses into the right window. The new mask and the new window selection must then take effect together on that pixel. The bench provokes this by driving random switch values in the same cycle as the boundary columns. It also changes the switches while the enable is low and then raises it. A behavioural model computes the expected colour from the position and switches of that edge alone, and it is compared every cycle.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_t;

endpackage

// File: rtl/vdc_window_decode.sv
module vdc_window_decode
  import vdc_pkg::*;
#(
  parameter int CW      = 10,
  parameter int IMG_W   = 224,
  parameter int IMG_H   = 224,
  parameter int LEFT_X  = 96,
  parameter int RIGHT_X = 416,
  parameter int TOP_Y   = 128,
  parameter int AW      = 16
) (
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] vcount,
  input  logic          active,
  output win_e          win,
  output logic [AW-1:0] addr
);

  localparam int NWIN = 2;
  localparam logic [CW-1:0] Y_LO = CW'(TOP_Y);
  localparam logic [CW-1:0] Y_HI = CW'(TOP_Y + IMG_H);

  logic            row_hit;
  logic [CW-1:0]   row_off;
  logic [NWIN-1:0] col_hit;
  logic [CW-1:0]   col_off [NWIN];
  logic [CW-1:0]   sel_col;

  assign row_hit = (vcount >= Y_LO) && (vcount < Y_HI);
  assign row_off = vcount - Y_LO;

  // one column comparator per window copy
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int START = (i == 0) ? LEFT_X : RIGHT_X;
    localparam logic [CW-1:0] X_LO = CW'(START);
    localparam logic [CW-1:0] X_HI = CW'(START + IMG_W);
    assign col_hit[i] = (hcount >= X_LO) && (hcount < X_HI);
    assign col_off[i] = hcount - X_LO;
  end

  always_comb begin
    win     = WIN_NONE;
    sel_col = '0;
    if (active && row_hit) begin
      if (col_hit[0]) begin
        win     = WIN_LEFT;
        sel_col = col_off[0];
      end else if (col_hit[1]) begin
        win     = WIN_RIGHT;
        sel_col = col_off[1];
      end
    end
  end

  // constant multiply folds into shifts and adds
  always_comb begin
    if (win == WIN_NONE) addr = '0;
    else                 addr = AW'(row_off) * AW'(IMG_W) + AW'(sel_col);
  end

endmodule

// File: rtl/vdc_pattern_rom.sv
module vdc_pattern_rom
  import vdc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output rgb_t          q
);

  // built-in test picture: diagonal bands of all eight colours
  function automatic rgb_t pattern(input logic [AW-1:0] a);
    logic [2:0] s;
    s = a[7:5] + a[12:10];
    return rgb_t'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= pattern(addr);
  end

endmodule

// File: rtl/vdc_key_mask.sv
module vdc_key_mask #(
  parameter logic [2:0] SECRET = 3'b010
) (
  input  logic [2:0] key,
  output logic [2:0] mask
);

  // zero mask when the entered code is right
  assign mask = key ^ SECRET;

endmodule

// File: rtl/vga_dual_compositor.sv
module vga_dual_compositor
  import vdc_pkg::*;
#(
  parameter int         CW      = 10,
  parameter int         IMG_W   = 224,
  parameter int         IMG_H   = 224,
  parameter int         LEFT_X  = 96,
  parameter int         RIGHT_X = 416,
  parameter int         TOP_Y   = 128,
  parameter logic [2:0] SECRET  = 3'b010,
  parameter int         AW      = $clog2(IMG_W * IMG_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] vcount,
  input  logic          active,
  input  logic [2:0]    key_sw,
  output logic [AW-1:0] rom_addr,
  output logic          red,
  output logic          green,
  output logic          blue
);

  win_e       win_d;
  win_e       win_q;
  logic [2:0] mask_d;
  logic [2:0] mask_q;
  rgb_t       pix_q;
  rgb_t       pix_out;

  vdc_window_decode #(
    .CW(CW), .IMG_W(IMG_W), .IMG_H(IMG_H),
    .LEFT_X(LEFT_X), .RIGHT_X(RIGHT_X), .TOP_Y(TOP_Y), .AW(AW)
  ) u_decode (
    .hcount (hcount),
    .vcount (vcount),
    .active (active),
    .win    (win_d),
    .addr   (rom_addr)
  );

  vdc_pattern_rom #(.AW(AW)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (pix_en),
    .addr (rom_addr),
    .q    (pix_q)
  );

  vdc_key_mask #(.SECRET(SECRET)) u_mask (
    .key  (key_sw),
    .mask (mask_d)
  );

  // align selection and mask with the one-cycle memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= WIN_NONE;
      mask_q <= '0;
    end else if (pix_en) begin
      win_q  <= win_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (win_q)
      WIN_LEFT:  pix_out = pix_q;
      WIN_RIGHT: pix_out = pix_q ^ rgb_t'(mask_q);
      default:   pix_out = '0;
    endcase
  end

  assign red   = pix_out.r;
  assign green = pix_out.g;
  assign blue  = pix_out.b;

endmodule

// File: rtl/vga_dual_compositor_chk.sv
module vga_dual_compositor_chk #(
  parameter int CW     = 10,
  parameter int IMG_W  = 224,
  parameter int IMG_H  = 224,
  parameter int LEFT_X = 96,
  parameter int TOP_Y  = 128,
  parameter int AW     = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [CW-1:0] hcount,
  input logic [CW-1:0] vcount,
  input logic          active,
  input logic [2:0]    key_sw,
  input logic [AW-1:0] rom_addr,
  input logic          red,
  input logic          green,
  input logic          blue
);

  localparam int DEPTH = IMG_W * IMG_H;

  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> ({red, green, blue} == 3'b000));

  p_blank_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !active) |=> ({red, green, blue} == 3'b000));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!pix_en) |=> $stable({red, green, blue}));

  p_addr_range_r6: assert property (@(posedge clk) disable iff (rst)
    32'(rom_addr) < DEPTH);

  p_left_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (active && vcount == CW'(TOP_Y) && hcount == CW'(LEFT_X + 1))
      |-> (rom_addr == AW'(1)));

  p_key_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!pix_en && key_sw != $past(key_sw)) |=> $stable({red, green, blue}));

endmodule

bind vga_dual_compositor vga_dual_compositor_chk #(
  .CW(CW), .IMG_W(IMG_W), .IMG_H(IMG_H),
  .LEFT_X(LEFT_X), .TOP_Y(TOP_Y), .AW(AW)
) chk_i (.*);

// File: tb/vga_dual_compositor_tb_top.sv
`timescale 1ns/100ps
module vga_dual_compositor_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_en = 1'b0;
  logic [9:0] hcount = '0;
  logic [9:0] vcount = '0;
  logic       active = 1'b0;
  logic [2:0] key_sw = 3'b010;
  logic [15:0] rom_addr;
  logic       red, green, blue;

  int total = 0;
  int bad = 0;
  logic [2:0] exp_rgb = 3'b000;
  string exp_tag = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  vga_dual_compositor dut_i (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hcount(hcount), .vcount(vcount),
    .active(active), .key_sw(key_sw), .rom_addr(rom_addr),
    .red(red), .green(green), .blue(blue)
  );

  function automatic int ref_win(int x, int y, bit a);
    if (!a || y < 128 || y >= 352) return 0;
    if (x >= 96 && x < 320) return 1;
    if (x >= 416 && x < 640) return 2;
    return 0;
  endfunction

  function automatic int ref_addr(int x, int y, bit a);
    int w;
    w = ref_win(x, y, a);
    if (w == 0) return 0;
    return (y - 128) * 224 + x - ((w == 1) ? 96 : 416);
  endfunction

  function automatic int ref_pix(int a);
    return (((a >> 5) & 7) + ((a >> 10) & 7)) & 7;
  endfunction

  // reference model: one state update per clock edge
  always @(posedge clk) begin
    int w, x, y;
    if (rst) begin
      exp_rgb = 3'b000;
      exp_tag = "R1";
    end else if (pix_en) begin
      x = int'(hcount); y = int'(vcount);
      w = ref_win(x, y, active);
      if (w == 1) begin
        exp_rgb = 3'(ref_pix(ref_addr(x, y, active)));
        exp_tag = "R2";
      end else if (w == 2) begin
        exp_rgb = 3'(ref_pix(ref_addr(x, y, active))) ^ (key_sw ^ 3'b010);
        exp_tag = "R3";
      end else begin
        exp_rgb = 3'b000;
        exp_tag = "R5";
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if ({red, green, blue} !== exp_rgb) begin
        bad++;
        $display("FAIL %s colour actual=%b expected=%b", exp_tag, {red, green, blue}, exp_rgb);
      end
      total++;
      if (int'(rom_addr) != ref_addr(int'(hcount), int'(vcount), active)) begin
        bad++;
        $display("FAIL R6 address actual=%0d expected=%0d", rom_addr,
                 ref_addr(int'(hcount), int'(vcount), active));
      end
    end
  end

  task automatic drive(int x, int y, bit a, bit e, logic [2:0] k);
    @(posedge clk);
    #1;
    hcount = 10'(x); vcount = 10'(y); active = a; pix_en = e; key_sw = k;
  endtask

  task automatic check(string req, logic [2:0] act, logic [2:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  initial begin
    #(150000 * 5.0);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] cap, cap2;
    repeat (3) @(posedge clk);
    check("R1", {red, green, blue}, 3'b000);
    drive(150, 200, 1, 1, 3'b010);
    #1 rst = 0;
    @(posedge clk); #1;
    check("R1", {red, green, blue}, 3'b000);

    // R7: position (133,133) -> address 1157 -> word 3'b101
    drive(96 + 37, 128 + 5, 1, 1, 3'b010);
    @(posedge clk); #1;
    check("R7", {red, green, blue}, 3'b101);

    // R4: same image spot in both windows with the correct key
    for (int i = 0; i < 20; i++) begin
      int cx, cy;
      cx = 96 + int'($urandom_range(0, 223));
      cy = 128 + int'($urandom_range(0, 223));
      drive(cx, cy, 1, 1, 3'b010);
      @(posedge clk); #1; cap = {red, green, blue};
      drive(cx + 320, cy, 1, 1, 3'b010);
      @(posedge clk); #1; cap2 = {red, green, blue};
      check("R4", cap2, cap);
    end

    // R9: exact window edges, with switches changing on the same edge
    begin
      int xs[8] = '{95, 96, 319, 320, 415, 416, 639, 0};
      int ys[6] = '{127, 128, 351, 352, 200, 479};
      foreach (xs[i]) foreach (ys[j]) begin
        drive(xs[i], ys[j], 1, 1, 3'($urandom_range(0, 7)));
        @(posedge clk); #1;
        check("R9", {red, green, blue},
              (ref_win(xs[i], ys[j], 1) == 0) ? 3'b000 : exp_rgb);
      end
    end

    // R8 and R10: enable low while position and switches move
    for (int i = 0; i < 10; i++) begin
      drive(420 + i, 140 + i, 1, 1, 3'b111);
      @(posedge clk); #1; cap = {red, green, blue};
      for (int k = 0; k < 4; k++) begin
        drive(int'($urandom_range(0, 639)), int'($urandom_range(0, 479)), 1, 0,
              3'($urandom_range(0, 7)));
        @(posedge clk); #1;
        check("R8", {red, green, blue}, cap);
        check("R10", {red, green, blue}, cap);
      end
    end

    // R5: blanking flag low inside a window
    drive(200, 200, 0, 1, 3'b000);
    @(posedge clk); #1;
    check("R5", {red, green, blue}, 3'b000);

    // random traffic: R2, R3, R5, R6 compared every cycle by the model
    for (int i = 0; i < 6000; i++) begin
      int x, y;
      if ($urandom_range(0, 3) != 0) begin
        x = ($urandom_range(0, 1) == 1) ? 90 + int'($urandom_range(0, 240))
                                        : 410 + int'($urandom_range(0, 229));
        y = 120 + int'($urandom_range(0, 240));
      end else begin
        x = int'($urandom_range(0, 799));
        y = int'($urandom_range(0, 524));
      end
      drive(x, y, (x < 640 && y < 480) && ($urandom_range(0, 9) != 0),
            $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)));
    end

    // a short raster sweep with the enable every second clock
    for (int y = 126; y < 132; y++)
      for (int x = 0; x < 800; x++) begin
        drive(x, y, x < 640, 1, 3'b011);
        drive(x, y, x < 640, 0, 3'b011);
      end

    repeat (2) @(posedge clk);
    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule